// File: doc/BRIEF.md
# Two-Port Pixel Capture and Demultiplexer

This block takes pixels from a graphics source over two 12-bit input ports and delivers complete 24-bit pixels, each with a one-cycle valid strobe, on an internal bus. It has two capture modes. In the split mode, one pixel comes in as two 12-bit halves, one after the other, on whichever port is selected. In the wide mode, the two ports together carry a whole pixel in one transfer. The capture clock runs at either the pixel rate or twice the pixel rate. At the pixel rate, a split pixel's second half is the falling-edge sample, which the pad logic presents on a separate 12-bit input.

Sync can work in either direction. As a slave, the block watches the source's active-low vertical sync and leaves its own sync outputs inactive. As a master, it counts pixel slots against programmable line and frame totals, and drives active-low horizontal and vertical sync pulses of programmable width back to the source. A pixel-rate enable serves as the frequency reference for the source. The capture mode, port choice and clock ratio are latched only at a frame boundary, so a pixel can never be assembled from halves captured under different settings.

Top module: `pix_demux`

## Requirements
- R1: In wide mode at 1x clock, every clock produces `pixOut = {portA, portB}` (portA in bits [23:12]) with `pixValid` high, visible one clock after the data is sampled.
- R2: In wide mode at 2x clock, a pixel `{portA, portB}` is produced on every second clock only, so `pixValid` is high in exactly half of the cycles.
- R3: In split mode at 2x clock, the first half captured after a frame boundary fills bits [23:12] and the next half fills bits [11:0], and `pixValid` pulses once per completed pair.
- R4: In split mode at 1x clock, each clock produces a pixel with the selected port's value in bits [23:12] and `fallHalf` in bits [11:0].
- R5: In split mode, `cfgPortSel` = 0 takes halves from portA and 1 takes them from portB, and the port that is not selected has no effect on `pixOut`.
- R6: `pixRefEn` is high on every clock at 1x. At 2x it alternates and is high on the clock that samples the second half, starting low right after a frame boundary.
- R7: Changes to `cfgMuxMode`, `cfgPortSel` and `cfgClk2x` take effect only at a frame boundary, which is the falling edge of `vsIn` in slave mode or the counter wrap in master mode. Before that boundary, output follows the old setting. The first clock after reset also loads the configuration.
- R8: In slave mode (`cfgSyncMaster` = 0), `syncOe` is low and `hsOut` and `vsOut` are held high.
- R9: In master mode, `syncOe` is high. `hsOut` is low for the first `cfgHsWidth` pixel slots of each `cfgHTotal`-slot line, and `vsOut` is low for the first `cfgVsWidth` lines of each `cfgVTotal`-line frame.
- R10: After reset, `pixValid` is low and `pixOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMuxMode | input | 1 | 1 = split 2x12 capture, 0 = wide 1x24 capture |
| cfgPortSel | input | 1 | Port used for split capture: 0 = portA, 1 = portB |
| cfgClk2x | input | 1 | 1 = clock runs at twice the pixel rate |
| cfgSyncMaster | input | 1 | 1 = block generates sync, 0 = block follows vsIn |
| cfgHTotal | input | 11 | Pixel slots per line (master mode) |
| cfgVTotal | input | 11 | Lines per frame (master mode) |
| cfgHsWidth | input | 11 | Horizontal sync width in slots |
| cfgVsWidth | input | 11 | Vertical sync width in lines |
| portA | input | 12 | First input port |
| portB | input | 12 | Second input port |
| fallHalf | input | 12 | Falling-edge sample of the selected port (1x split mode) |
| vsIn | input | 1 | Active-low vertical sync from the source |
| pixOut | output | 24 | Assembled pixel |
| pixValid | output | 1 | One-cycle strobe for each new pixel |
| pixRefEn | output | 1 | Pixel-rate reference enable |
| hsOut | output | 1 | Generated horizontal sync, active low |
| vsOut | output | 1 | Generated vertical sync, active low |
| syncOe | output | 1 | High when the sync outputs are driven |

## Verification
On every cycle, the assertions check four things: the active configuration changes only in a cycle that loads it, a valid pixel always follows a reference-enable slot, the reference enable alternates while the 2x ratio is active, and the sync outputs stay high whenever they are not driven. Only the bench scenarios can show the data itself. That covers the bit order of the two halves, which port supplies them, the fact that a mode change is delayed until the vertical sync edge, and the widths of the generated sync pulses over a full frame.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
  typedef struct packed {
    logic muxMode;
    logic portSel;
    logic clk2x;
  } pd_cfg_t;

  typedef struct packed {
    logic capHi;
    logic emitPair;
    logic emitFall;
    logic emitWide;
  } pd_strobe_t;
endpackage

// File: rtl/pix_demux_ctrl.sv
module pix_demux_ctrl
  import pix_demux_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  pd_cfg_t          cfgIn,
  input  logic             syncMaster,
  input  logic [CNT_W-1:0] hTotal,
  input  logic [CNT_W-1:0] vTotal,
  input  logic [CNT_W-1:0] hsWidth,
  input  logic [CNT_W-1:0] vsWidth,
  input  logic             vsIn,
  output pd_cfg_t          actCfg,
  output logic             cfgLoad,
  output pd_strobe_t       strobe,
  output logic             pixEn,
  output logic             hsOut,
  output logic             vsOut,
  output logic             syncOe
);
  logic             phase;
  logic             loaded;
  logic             vsInD;
  logic [CNT_W-1:0] hCnt;
  logic [CNT_W-1:0] vCnt;
  logic             lineEnd;
  logic             frameEnd;
  logic             vsFall;

  assign pixEn    = actCfg.clk2x ? phase : 1'b1;
  assign lineEnd  = (hCnt == hTotal - 1'b1);
  assign frameEnd = pixEn && lineEnd && (vCnt == vTotal - 1'b1);
  assign vsFall   = vsInD && !vsIn;
  assign cfgLoad  = !loaded || (syncMaster ? frameEnd : vsFall);

  always_comb begin
    strobe = '0;
    if (actCfg.muxMode) begin
      if (actCfg.clk2x) begin
        strobe.capHi    = !phase;
        strobe.emitPair = phase;
      end else begin
        strobe.emitFall = 1'b1;
      end
    end else begin
      strobe.emitWide = pixEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCfg <= '0;
      loaded <= 1'b0;
      phase  <= 1'b0;
      vsInD  <= 1'b1;
    end else begin
      vsInD <= vsIn;
      if (cfgLoad) begin
        actCfg <= cfgIn;
        loaded <= 1'b1;
        phase  <= 1'b0;
      end else if (actCfg.clk2x) begin
        phase <= ~phase;
      end else begin
        phase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !syncMaster) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (pixEn) begin
      if (lineEnd) begin
        hCnt <= '0;
        vCnt <= (vCnt == vTotal - 1'b1) ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  assign syncOe = syncMaster;
  assign hsOut  = syncMaster ? (hCnt >= hsWidth) : 1'b1;
  assign vsOut  = syncMaster ? (vCnt >= vsWidth) : 1'b1;
endmodule

// File: rtl/pix_demux_dp.sv
module pix_demux_dp
  import pix_demux_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int PIX_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pd_strobe_t        strobe,
  input  logic              portSel,
  input  logic [HALF_W-1:0] portA,
  input  logic [HALF_W-1:0] portB,
  input  logic [HALF_W-1:0] fallHalf,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixValid
);
  logic [HALF_W-1:0] selHalf;
  logic [HALF_W-1:0] hiReg;

  assign selHalf = portSel ? portB : portA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= strobe.emitPair | strobe.emitFall | strobe.emitWide;
      if (strobe.capHi)    hiReg  <= selHalf;
      if (strobe.emitPair) pixOut <= {hiReg, selHalf};
      if (strobe.emitFall) pixOut <= {selHalf, fallHalf};
      if (strobe.emitWide) pixOut <= {portA, portB};
    end
  end
endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pix_demux_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int CNT_W  = 11,
  localparam int PIX_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMuxMode,
  input  logic              cfgPortSel,
  input  logic              cfgClk2x,
  input  logic              cfgSyncMaster,
  input  logic [CNT_W-1:0]  cfgHTotal,
  input  logic [CNT_W-1:0]  cfgVTotal,
  input  logic [CNT_W-1:0]  cfgHsWidth,
  input  logic [CNT_W-1:0]  cfgVsWidth,
  input  logic [HALF_W-1:0] portA,
  input  logic [HALF_W-1:0] portB,
  input  logic [HALF_W-1:0] fallHalf,
  input  logic              vsIn,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixValid,
  output logic              pixRefEn,
  output logic              hsOut,
  output logic              vsOut,
  output logic              syncOe
);
  pd_cfg_t    cfgIn;
  pd_cfg_t    actCfg;
  pd_strobe_t strobe;
  logic       cfgLoad;

  assign cfgIn = '{muxMode: cfgMuxMode, portSel: cfgPortSel, clk2x: cfgClk2x};

  pix_demux_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .syncMaster(cfgSyncMaster),
    .hTotal(cfgHTotal), .vTotal(cfgVTotal), .hsWidth(cfgHsWidth),
    .vsWidth(cfgVsWidth), .vsIn(vsIn), .actCfg(actCfg), .cfgLoad(cfgLoad),
    .strobe(strobe), .pixEn(pixRefEn), .hsOut(hsOut), .vsOut(vsOut),
    .syncOe(syncOe)
  );

  pix_demux_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .portSel(actCfg.portSel),
    .portA(portA), .portB(portB), .fallHalf(fallHalf),
    .pixOut(pixOut), .pixValid(pixValid)
  );
endmodule

// File: rtl/pix_demux_chk.sv
module pix_demux_chk
  import pix_demux_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input pd_cfg_t actCfg,
  input logic    cfgLoad,
  input logic    pixValid,
  input logic    pixRefEn,
  input logic    hsOut,
  input logic    vsOut,
  input logic    syncOe
);
  AST_CFG_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgLoad) |-> $stable(actCfg)); // R7

  AST_VALID_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $past(pixRefEn)); // R2

  AST_REF_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    (actCfg.clk2x && $past(actCfg.clk2x) && !$past(cfgLoad)) |-> (pixRefEn != $past(pixRefEn))); // R6

  AST_IDLE_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !syncOe |-> (hsOut && vsOut)); // R8
endmodule

bind pix_demux pix_demux_chk u_chk (
  .clk(clk), .rstN(rstN), .actCfg(actCfg), .cfgLoad(cfgLoad),
  .pixValid(pixValid), .pixRefEn(pixRefEn), .hsOut(hsOut), .vsOut(vsOut),
  .syncOe(syncOe)
);

// File: tb/pix_demux_tb.sv
module pix_demux_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMuxMode = 1'b0, cfgPortSel = 1'b0, cfgClk2x = 1'b0, cfgSyncMaster = 1'b0;
  logic [10:0] cfgHTotal = 11'd8, cfgVTotal = 11'd4, cfgHsWidth = 11'd2, cfgVsWidth = 11'd1;
  logic [11:0] portA = '0, portB = '0, fallHalf = '0;
  logic        vsIn = 1'b1;
  logic [23:0] pixOut;
  logic        pixValid, pixRefEn, hsOut, vsOut, syncOe;
  int          nChk = 0, nErr = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  pix_demux u_dut (
    .clk(clk), .rstN(rstN), .cfgMuxMode(cfgMuxMode), .cfgPortSel(cfgPortSel),
    .cfgClk2x(cfgClk2x), .cfgSyncMaster(cfgSyncMaster), .cfgHTotal(cfgHTotal),
    .cfgVTotal(cfgVTotal), .cfgHsWidth(cfgHsWidth), .cfgVsWidth(cfgVsWidth),
    .portA(portA), .portB(portB), .fallHalf(fallHalf), .vsIn(vsIn),
    .pixOut(pixOut), .pixValid(pixValid), .pixRefEn(pixRefEn),
    .hsOut(hsOut), .vsOut(vsOut), .syncOe(syncOe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic vsPulse();
    vsIn = 1'b0;
    tick();
    vsIn = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10 valid", {31'd0, pixValid}, 32'd0);
    chk("R10 pix", {8'd0, pixOut}, 32'd0);
    chk("R8 oe", {31'd0, syncOe}, 32'd0);
    chk("R8 hs/vs", {30'd0, hsOut, vsOut}, 32'd3);
  endtask

  task automatic t_wide1x();
    for (int i = 0; i < 3; i++) begin
      portA = 12'h100 + 12'(i); portB = 12'hA50 + 12'(i);
      tick();
      chk("R1 pix", {8'd0, pixOut}, {8'd0, 12'h100 + 12'(i), 12'hA50 + 12'(i)});
      chk("R1 valid", {31'd0, pixValid}, 32'd1);
      chk("R6 ref 1x", {31'd0, pixRefEn}, 32'd1);
    end
  endtask

  task automatic t_split2x();
    cfgMuxMode = 1'b1; cfgClk2x = 1'b1; cfgPortSel = 1'b1;
    portA = 12'h111; portB = 12'h222;
    tick();
    chk("R7 old mode kept", {8'd0, pixOut}, {8'd0, 24'h111222});
    portA = 12'h333; portB = 12'h444;
    vsPulse();
    chk("R7 load edge old mode", {8'd0, pixOut}, {8'd0, 24'h333444});
    chk("R6 ref low after boundary", {31'd0, pixRefEn}, 32'd0);
    portB = 12'hABC; portA = 12'hFFF;
    tick();
    chk("R3 no valid mid pair", {31'd0, pixValid}, 32'd0);
    chk("R6 ref high 2nd half", {31'd0, pixRefEn}, 32'd1);
    portB = 12'hDEF; portA = 12'h000;
    tick();
    chk("R3 pair", {8'd0, pixOut}, {8'd0, 24'hABCDEF});
    chk("R3 valid", {31'd0, pixValid}, 32'd1);
    chk("R5 portB used, portA ignored", {8'd0, pixOut}, {8'd0, 24'hABCDEF});
  endtask

  task automatic t_split1x();
    cfgMuxMode = 1'b1; cfgClk2x = 1'b0; cfgPortSel = 1'b0;
    vsPulse();
    portA = 12'h5A5; fallHalf = 12'h3C3; portB = 12'h999;
    tick();
    chk("R4 pix", {8'd0, pixOut}, {8'd0, 24'h5A53C3});
    chk("R4 valid", {31'd0, pixValid}, 32'd1);
    portB = 12'h777;
    tick();
    chk("R5 portB ignored", {8'd0, pixOut}, {8'd0, 24'h5A53C3});
  endtask

  task automatic t_wide2x();
    int nv = 0;
    cfgMuxMode = 1'b0; cfgClk2x = 1'b1;
    vsPulse();
    portA = 12'h0F0; portB = 12'h00F;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (pixValid) nv++;
    end
    chk("R2 valid count", nv, 32'd4);
    chk("R2 pix", {8'd0, pixOut}, {8'd0, 24'h0F000F});
  endtask

  task automatic t_master();
    int nh = 0, nvs = 0;
    cfgClk2x = 1'b0;
    vsPulse();
    cfgSyncMaster = 1'b1;
    tick();
    chk("R9 oe", {31'd0, syncOe}, 32'd1);
    for (int i = 0; i < 32; i++) begin
      if (!hsOut) nh++;
      if (!vsOut) nvs++;
      tick();
    end
    chk("R9 hs low slots", nh, 32'd8);
    chk("R9 vs low slots", nvs, 32'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    tick();
    t_wide1x();
    t_split2x();
    t_split1x();
    t_wide2x();
    t_master();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule